// File: doc/BRIEF.md
# Addressed Serial Frame Receiver for a Segment Display Driver

This block takes a three-wire serial link (enable, bit clock, data) from a host controller and turns it into the stored state of a multiplexed segment display driver: a flat segment bitmap and a decoded configuration word. A frame starts with an 8-bit device address clocked in while enable is low. Enable then rises, and exactly 72 payload bits follow. The last two bits of the payload name the group that the payload belongs to. The bitmap is loaded in up to four groups. Only the first group also carries the configuration field.

All three serial pins are oversampled by the block clock, passed through a synchronizer, and edge-detected. The link therefore works whether the bit clock rests high or low between frames. A frame is committed only at the falling edge of enable, and only when the address matched and the bit count was exact. The serial link has no back-pressure: the host may send at any rate that the oversampling clock can resolve, and the receiver never stalls it. The bitmap and configuration outputs are plain levels that change only in the cycle after a commit.

Top module: `sfr_rx_top`

## Requirements
- R1: The address is 8 bits, sent least significant bit first, sampled on rising bit-clock edges while enable is low. Only the last 8 such bits count. A frame is accepted only if they equal 41h; any other address changes nothing.
- R2: While enable is high, every rising bit-clock edge shifts in one payload bit. A frame with fewer or more than 72 bits changes nothing.
- R3: The two last-arriving payload bits form the group number, with the earlier of the two as the high bit: 00, 01, 10 and 11 select groups 0, 1, 2 and 3.
- R4: In 4-multiplex mode, groups 0 to 3 write segment bits 0-51, 52-103, 104-151 and 152-207. Each group takes its first 52, 52, 48 or 56 arriving payload bits, in order, with the first bit at the lowest index. The remaining payload bits of a group are ignored.
- R5: In 3-multiplex mode, groups 0 to 2 write segment bits 0-53, 54-107 and 108-158 from their first 54, 54 or 51 payload bits. A group-3 frame in this mode changes nothing.
- R6: For a group-0 frame, the mode that picks the split (52 or 54 bits) is the mode bit carried in that same frame. For groups 1 to 3, the split uses the stored mode bit.
- R7: Only a group-0 frame loads the configuration. Payload bits 56 to 69 (0 = first arriving) map in arrival order onto: clock-out select (2 bits), slow external clock, port select (3 bits), 3-multiplex mode, extra segment enable, frame-rate select (3 bits), external clock mode, blank, and power save. Each multi-bit field has its first-arriving bit as its most significant bit.
- R8: Frames are received correctly whether the bit clock rests high or low around enable transitions.
- R9: After reset the bitmap and configuration are all zero. A good frame is committed once, at the falling edge of enable, and the outputs hold steady at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en | input | 1 | Serial enable (low: address phase, high: payload phase) |
| ser_clk | input | 1 | Serial bit clock, sampled on rising edges |
| ser_dat | input | 1 | Serial data |
| seg_bits | output | NSEG | Segment bitmap, index 0 = first display bit of group 0 |
| cfg_pclk_sel | output | 2 | Clock-out select field |
| cfg_ext_slow | output | 1 | Slow external clock select |
| cfg_port_sel | output | 3 | Segment/port pin switching field |
| cfg_duty3 | output | 1 | 3-multiplex mode when 1, 4-multiplex when 0 |
| cfg_seg_ext | output | 1 | Extra segment pins enable |
| cfg_frame_sel | output | 3 | Frame-rate select field |
| cfg_ext_clk | output | 1 | External clock mode |
| cfg_blank | output | 1 | Segments forced off |
| cfg_save | output | 1 | Power-save mode |

## Verification
The bench targets frames that are one bit short or one bit long. A design that commits on a loose count would corrupt a group with shifted data. It also sends a wrong address and a group-3 frame in 3-multiplex mode; a design that did not filter these would overwrite bitmap bits. It sends group-0 frames that flip the mode bit, which show whether the split follows the incoming bit or the stale stored one; a wrong choice moves bits 52 and 53 by one group. It also mixes frames with the bit clock resting high and resting low. A design that detected a spurious edge at enable transitions would be off by one bit in every field.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  // Position of the configuration field inside a group-0 payload (arrival index)
  localparam int CTRL_POS = 56;
  localparam int CTRL_W   = 14;
  // Offset of the multiplex-mode bit inside the configuration field
  localparam int DT_OFS   = 6;

  typedef struct packed {
    logic [1:0] pclk_sel;
    logic       ext_slow;
    logic [2:0] port_sel;
    logic       duty3;
    logic       seg_ext;
    logic [2:0] frame_sel;
    logic       ext_clk;
    logic       blank;
    logic       save;
  } ctrl_t;

  function automatic logic [7:0] grp_base(input logic duty3, input logic [1:0] g);
    logic [7:0] b;
    if (duty3) begin
      case (g)
        2'd0:    b = 8'd0;
        2'd1:    b = 8'd54;
        2'd2:    b = 8'd108;
        default: b = 8'd159;
      endcase
    end else begin
      case (g)
        2'd0:    b = 8'd0;
        2'd1:    b = 8'd52;
        2'd2:    b = 8'd104;
        default: b = 8'd152;
      endcase
    end
    return b;
  endfunction

  function automatic logic [7:0] grp_len(input logic duty3, input logic [1:0] g);
    logic [7:0] n;
    if (duty3) begin
      case (g)
        2'd0:    n = 8'd54;
        2'd1:    n = 8'd54;
        2'd2:    n = 8'd51;
        default: n = 8'd0;
      endcase
    end else begin
      case (g)
        2'd0:    n = 8'd52;
        2'd1:    n = 8'd52;
        2'd2:    n = 8'd48;
        default: n = 8'd56;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign lvl[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/sfr_shift.sv
module sfr_shift #(
  parameter logic [7:0] DEV_ADDR   = 8'h41,
  parameter int         FRAME_BITS = 72,
  localparam int        CW         = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_lvl,
  input  logic                  en_rise,
  input  logic                  en_fall,
  input  logic                  sclk_rise,
  input  logic                  dat,
  output logic                  frame_ok,
  output logic [FRAME_BITS-1:0] payload,
  output logic [CW-1:0]         bit_cnt
);

  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] CNT_OVER = CW'(FRAME_BITS + 1);

  logic [7:0] addr_sr;
  logic       hit;

  // Address: least significant bit first, newest bit enters at the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_sr <= '0;
    else if (sclk_rise && !en_lvl) addr_sr <= {dat, addr_sr[7:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit     <= 1'b0;
      bit_cnt <= '0;
      payload <= '0;
    end else if (en_rise) begin
      hit     <= (addr_sr == DEV_ADDR);
      bit_cnt <= '0;
    end else if (en_fall) begin
      hit     <= 1'b0;
    end else if (sclk_rise && en_lvl) begin
      payload <= {payload[FRAME_BITS-2:0], dat};
      if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign frame_ok = en_fall && hit && (bit_cnt == CNT_FULL);

endmodule

// File: rtl/sfr_bank.sv
module sfr_bank
  import sfr_pkg::*;
#(
  parameter int FRAME_BITS = 72,
  parameter int NSEG       = 208
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [FRAME_BITS-1:0] payload,
  output logic [NSEG-1:0]       seg_bits,
  output ctrl_t                 cfg
);

  localparam int PADW = NSEG - FRAME_BITS;

  logic [FRAME_BITS-1:0] arr;      // arr[k] = k-th arriving bit
  logic [1:0]            grp;
  logic                  duty3;
  logic                  accept;
  logic [7:0]            base;
  logic [7:0]            len;
  logic [NSEG-1:0]       win;
  logic [NSEG-1:0]       lenmask;
  logic [NSEG-1:0]       mask;
  logic [NSEG-1:0]       seg_nxt;
  logic [CTRL_W-1:0]     cfield;
  logic [NSEG-1:0]       seg_q;
  ctrl_t                 cfg_q;

  for (genvar k = 0; k < FRAME_BITS; k++) begin : g_order
    assign arr[k] = payload[FRAME_BITS-1-k];
  end

  assign grp    = payload[1:0];
  assign duty3  = (grp == 2'b00) ? arr[CTRL_POS + DT_OFS] : cfg_q.duty3;
  assign accept = !(duty3 && (grp == 2'b11));
  assign base   = grp_base(duty3, grp);
  assign len    = grp_len(duty3, grp);

  always_comb begin
    win     = {{PADW{1'b0}}, arr};
    lenmask = ~({NSEG{1'b1}} << len);
    mask    = lenmask << base;
    seg_nxt = (seg_q & ~mask) | ((win & lenmask) << base);
    for (int i = 0; i < CTRL_W; i++) cfield[CTRL_W-1-i] = arr[CTRL_POS + i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      cfg_q <= '0;
    end else if (commit && accept) begin
      seg_q <= seg_nxt;
      if (grp == 2'b00) cfg_q <= ctrl_t'(cfield);
    end
  end

  assign seg_bits = seg_q;
  assign cfg      = cfg_q;

endmodule

// File: rtl/sfr_rx_top.sv
module sfr_rx_top
  import sfr_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR    = 8'h41,
  parameter int         FRAME_BITS  = 72,
  parameter int         NSEG        = 208,
  parameter int         SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_en,
  input  logic            ser_clk,
  input  logic            ser_dat,
  output logic [NSEG-1:0] seg_bits,
  output logic [1:0]      cfg_pclk_sel,
  output logic            cfg_ext_slow,
  output logic [2:0]      cfg_port_sel,
  output logic            cfg_duty3,
  output logic            cfg_seg_ext,
  output logic [2:0]      cfg_frame_sel,
  output logic            cfg_ext_clk,
  output logic            cfg_blank,
  output logic            cfg_save
);

  localparam int CW = $clog2(FRAME_BITS + 2);

  logic [2:0]            s_lvl;
  logic                  en_d;
  logic                  sclk_d;
  logic                  en_rise;
  logic                  en_fall;
  logic                  sclk_rise;
  logic                  frame_ok;
  logic [FRAME_BITS-1:0] payload;
  logic [CW-1:0]         bit_cnt;
  ctrl_t                 cfg;

  sfr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({ser_en, ser_clk, ser_dat}),
    .lvl   (s_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      en_d   <= s_lvl[2];
      sclk_d <= s_lvl[1];
    end
  end

  assign en_rise   = s_lvl[2] & ~en_d;
  assign en_fall   = ~s_lvl[2] & en_d;
  assign sclk_rise = s_lvl[1] & ~sclk_d;

  sfr_shift #(.DEV_ADDR(DEV_ADDR), .FRAME_BITS(FRAME_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_lvl    (s_lvl[2]),
    .en_rise   (en_rise),
    .en_fall   (en_fall),
    .sclk_rise (sclk_rise),
    .dat       (s_lvl[0]),
    .frame_ok  (frame_ok),
    .payload   (payload),
    .bit_cnt   (bit_cnt)
  );

  sfr_bank #(.FRAME_BITS(FRAME_BITS), .NSEG(NSEG)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (frame_ok),
    .payload  (payload),
    .seg_bits (seg_bits),
    .cfg      (cfg)
  );

  assign cfg_pclk_sel  = cfg.pclk_sel;
  assign cfg_ext_slow  = cfg.ext_slow;
  assign cfg_port_sel  = cfg.port_sel;
  assign cfg_duty3     = cfg.duty3;
  assign cfg_seg_ext   = cfg.seg_ext;
  assign cfg_frame_sel = cfg.frame_sel;
  assign cfg_ext_clk   = cfg.ext_clk;
  assign cfg_blank     = cfg.blank;
  assign cfg_save      = cfg.save;

endmodule

// File: rtl/sfr_rx_chk.sv
module sfr_rx_chk #(
  parameter int FRAME_BITS = 72,
  parameter int NSEG       = 208,
  parameter int CW         = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            commit,
  input logic [1:0]      grp,
  input logic [CW-1:0]   bit_cnt,
  input logic [NSEG-1:0] seg_bits,
  input logic [13:0]     cfg
);

  // R9
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> $stable(seg_bits));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(commit) && ($past(grp) == 2'b00)) |-> $stable(cfg));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(FRAME_BITS + 1));

  // R9
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

endmodule

bind sfr_rx_top sfr_rx_chk #(
  .FRAME_BITS (FRAME_BITS),
  .NSEG       (NSEG),
  .CW         (CW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .commit   (frame_ok),
  .grp      (payload[1:0]),
  .bit_cnt  (bit_cnt),
  .seg_bits (seg_bits),
  .cfg      (cfg)
);

// File: tb/tb_sfr_rx_top.sv
module tb_sfr_rx_top;

  localparam int NSEG = 208;
  localparam int H    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic [NSEG-1:0] seg_bits;
  logic [1:0] cfg_pclk_sel;
  logic cfg_ext_slow;
  logic [2:0] cfg_port_sel;
  logic cfg_duty3;
  logic cfg_seg_ext;
  logic [2:0] cfg_frame_sel;
  logic cfg_ext_clk;
  logic cfg_blank;
  logic cfg_save;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [NSEG-1:0] exp_seg = '0;
  logic [13:0]     exp_cfg = '0;

  always #5 clk = ~clk;

  sfr_rx_top dut (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .seg_bits(seg_bits), .cfg_pclk_sel(cfg_pclk_sel), .cfg_ext_slow(cfg_ext_slow),
    .cfg_port_sel(cfg_port_sel), .cfg_duty3(cfg_duty3), .cfg_seg_ext(cfg_seg_ext),
    .cfg_frame_sel(cfg_frame_sel), .cfg_ext_clk(cfg_ext_clk), .cfg_blank(cfg_blank),
    .cfg_save(cfg_save)
  );

  function automatic logic [13:0] cfg_now();
    return {cfg_pclk_sel, cfg_ext_slow, cfg_port_sel, cfg_duty3, cfg_seg_ext,
            cfg_frame_sel, cfg_ext_clk, cfg_blank, cfg_save};
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_state(input string tag);
    checks++;
    if (seg_bits !== exp_seg) begin
      errors++;
      $display("FAIL %s bitmap: actual=%h expected=%h", tag, seg_bits, exp_seg);
    end
    checks++;
    if (cfg_now() !== exp_cfg) begin
      errors++;
      $display("FAIL %s config: actual=%h expected=%h", tag, cfg_now(), exp_cfg);
    end
  endtask

  // Bench model: f[k] is the k-th transmitted payload bit
  task automatic model(input logic [71:0] f);
    logic [1:0] g;
    logic d3;
    int b;
    int n;
    g  = {f[70], f[71]};
    d3 = (g == 2'd0) ? f[62] : exp_cfg[7];
    if (d3) begin
      b = (g == 2'd0) ? 0 : (g == 2'd1) ? 54 : 108;
      n = (g == 2'd2) ? 51 : (g == 2'd3) ? 0 : 54;
    end else begin
      b = (g == 2'd0) ? 0 : (g == 2'd1) ? 52 : (g == 2'd2) ? 104 : 152;
      n = (g == 2'd2) ? 48 : (g == 2'd3) ? 56 : 52;
    end
    for (int i = 0; i < n; i++) exp_seg[b + i] = f[i];
    if (g == 2'd0)
      for (int i = 0; i < 14; i++) exp_cfg[13 - i] = f[56 + i];
  endtask

  task automatic bit_out(input logic b, input bit idle_hi);
    if (idle_hi) begin
      ser_clk = 1'b0; ser_dat = b; wait_cyc(H);
      ser_clk = 1'b1; wait_cyc(H);
    end else begin
      ser_dat = b; wait_cyc(H);
      ser_clk = 1'b1; wait_cyc(H);
      ser_clk = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] a, input logic [71:0] f, input int n, input bit idle_hi);
    ser_clk = idle_hi; wait_cyc(H);
    for (int i = 0; i < 8; i++) bit_out(a[i], idle_hi);
    wait_cyc(H);
    ser_en = 1'b1; wait_cyc(H);
    for (int i = 0; i < n; i++) bit_out((i < 72) ? f[i] : 1'b1, idle_hi);
    wait_cyc(H);
    ser_en = 1'b0;
    wait_cyc(10);
  endtask

  function automatic logic [71:0] rnd72();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [71:0] with_grp(input logic [71:0] f, input logic [1:0] g,
                                           input int dt);
    logic [71:0] r;
    r = f;
    r[70] = g[1];
    r[71] = g[0];
    if (dt >= 0) r[62] = dt[0];
    return r;
  endfunction

  task automatic good(input logic [71:0] f, input bit idle_hi, input string tag);
    send(8'h41, f, 72, idle_hi);
    model(f);
    check_state(tag);
  endtask

  initial begin
    logic [71:0] f;
    void'($urandom(32'h5eed_1234));
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    check_state("R9 reset");

    // 4-multiplex mode, all groups
    good(with_grp(rnd72(), 2'd0, 0), 1'b0, "R4 R7 group0 4mux");
    good(with_grp(rnd72(), 2'd1, -1), 1'b0, "R3 R4 group1");
    good(with_grp(rnd72(), 2'd2, -1), 1'b0, "R3 R4 group2");
    good(with_grp(rnd72(), 2'd3, -1), 1'b0, "R3 R4 group3");

    // wrong address and wrong counts change nothing
    send(8'h42, with_grp(rnd72(), 2'd1, -1), 72, 1'b0);
    check_state("R1 address 42h");
    send(8'h82, with_grp(rnd72(), 2'd0, 1), 72, 1'b0);
    check_state("R1 address bit order");
    send(8'h41, with_grp(rnd72(), 2'd2, -1), 71, 1'b0);
    check_state("R2 71 bits");
    send(8'h41, with_grp(rnd72(), 2'd3, -1), 73, 1'b0);
    check_state("R2 73 bits");

    // 3-multiplex mode selected by the group-0 frame itself
    good(with_grp(rnd72(), 2'd0, 1), 1'b0, "R6 R5 group0 3mux");
    good(with_grp(rnd72(), 2'd1, -1), 1'b0, "R5 group1 3mux");
    good(with_grp(rnd72(), 2'd2, -1), 1'b0, "R5 group2 3mux");
    f = with_grp(rnd72(), 2'd3, -1);
    send(8'h41, f, 72, 1'b0);
    check_state("R5 group3 ignored in 3mux");
    good(with_grp(rnd72(), 2'd0, 0), 1'b0, "R6 back to 4mux");

    // bit clock resting high
    good(with_grp(rnd72(), 2'd0, 1), 1'b1, "R8 idle high group0");
    good(with_grp(rnd72(), 2'd1, -1), 1'b1, "R8 idle high group1");
    good(with_grp(rnd72(), 2'd0, 0), 1'b1, "R8 idle high group0 4mux");
    good(with_grp(rnd72(), 2'd3, -1), 1'b0, "R8 idle low after high");

    // random mix
    for (int t = 0; t < 40; t++) begin
      int kind;
      bit ih;
      logic [1:0] g;
      kind = $urandom_range(0, 9);
      ih   = $urandom_range(0, 1);
      g    = 2'($urandom_range(0, 3));
      f    = with_grp(rnd72(), g, -1);
      if (kind == 0) begin
        send(8'($urandom_range(0, 255)) | 8'h80, f, 72, ih);
        check_state("R1 random bad address");
      end else if (kind == 1) begin
        send(8'h41, f, $urandom_range(1, 2) == 1 ? 70 : 74, ih);
        check_state("R2 random bad count");
      end else begin
        good(f, ih, "R3 R9 random frame");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule